// File: doc/BRIEF.md
# Streaming Box-Average Filter

This block smooths a raster pixel stream with a square averaging kernel of side 2·RADIUS+1 (15×15 by default). It keeps one running vertical sum per image column in a line buffer. Each accepted pixel updates its column sum with one addition and one subtraction. A horizontal running sum over the most recent 2·RADIUS+1 column sums is updated the same way. The work per pixel is therefore the same for every radius.

The surrounding pixel line buffers are outside the block. For every beat the caller supplies two pixels of the current column: the pixel that enters the vertical window and the pixel that leaves it. The leaving pixel is the one 2·RADIUS+1 rows above, or zero while fewer rows have passed. The box sum is scaled by a fixed-point reciprocal of the kernel area and rounded. The result is emitted with a valid flag only for positions whose full window lies inside the frame.

Top module: `boxavg_stream`

## Requirements
- R1: After reset, and until pixels have been accepted, `out_valid` is 0.
- R2: A pixel accepted on a clock edge with `in_valid` high produces its result on the second following edge: `out_valid` is high in the cycle after the next cycle.
- R3: For the pixel at row r, column c (counted from 0 at the frame start), `out_pix` is the average of the 15×15 window covering rows r-14..r and columns c-14..c.
- R4: A result is produced for every accepted pixel with r ≥ 2·RADIUS and c ≥ 2·RADIUS, in stream order, and for no other pixel. The start-of-frame pixel never yields a result.
- R5: The column sum is the stored sum plus `in_add` minus `in_sub`. In row 0 of a frame the stored sum is taken as zero, and it never exceeds (2·RADIUS+1)·(2^PIX_W-1) when the caller supplies the pixel 2·RADIUS+1 rows above as `in_sub` (zero before that row).
- R6: A beat with `in_sof` high is row 0, column 0 of a new frame, even mid-frame. No column or box sum of the interrupted frame affects the new one.
- R7: Cycles with `in_valid` low change no state and produce no result, whatever the data inputs carry.
- R8: The box sum never exceeds (2·RADIUS+1)²·(2^PIX_W-1), and a window of all 255 yields 255.
- R9: With rounding enabled (default), the result is the box sum divided by the area, rounded to nearest. A window sum of 112 gives 0 and 113 gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel beat qualifier |
| in_sof | input | 1 | This beat is the first pixel of a frame |
| in_add | input | PIX_W | Pixel entering the column window (current row) |
| in_sub | input | PIX_W | Pixel leaving the column window (2·RADIUS+1 rows above, 0 if none) |
| out_valid | output | 1 | Result qualifier |
| out_pix | output | PIX_W | Rounded window average |

## Verification
The bound-range properties assume that the caller's leaving pixel really is the one 2·RADIUS+1 rows above in the same column, or zero during the first rows. Otherwise the column sums would wrap. The bench builds each frame in a small image array and derives `in_sub` from that array, so this always holds. It also fills idle cycles with arbitrary data, which the properties ignore. Frames are 17 rows of 18 pixels each, always starting with `in_sof`.

// File: rtl/bx_pkg.sv
package bx_pkg;
   localparam int FRAC_BITS = 24;

   function automatic int sum_width(input int base_w, input int terms);
      return base_w + $clog2(terms);
   endfunction

   function automatic longint recip_of(input longint area);
      return ((64'sd1 <<< FRAC_BITS) + area / 2) / area;
   endfunction
endpackage

// File: rtl/bx_colsum.sv
module bx_colsum #(
   parameter int PIX_W  = 8,
   parameter int COL_W  = 12,
   parameter int IMG_W  = 64,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   input  logic              first_row,
   input  logic [PIX_W-1:0]  add_pix,
   input  logic [PIX_W-1:0]  sub_pix,
   output logic [COL_W-1:0]  col_new
);
   logic [COL_W-1:0] sums [IMG_W];
   logic [COL_W-1:0] base;

   always_comb begin
      base    = first_row ? '0 : sums[addr];
      col_new = base + COL_W'(add_pix) - COL_W'(sub_pix);
   end

   always_ff @(posedge clk) begin
      if (valid) sums[addr] <= col_new;
   end
endmodule

// File: rtl/bx_rowsum.sv
module bx_rowsum #(
   parameter int COL_W = 12,
   parameter int BOX_W = 16,
   parameter int TAPS  = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic             restart,
   input  logic             leave_en,
   input  logic [COL_W-1:0] col_new,
   output logic [BOX_W-1:0] box_sum
);
   logic [COL_W-1:0] taps [TAPS];
   logic [BOX_W-1:0] base, leaving, box_d;

   always_comb begin
      base    = restart ? '0 : box_sum;
      leaving = leave_en ? BOX_W'(taps[TAPS-1]) : '0;
      box_d   = base + BOX_W'(col_new) - leaving;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     box_sum <= '0;
      else if (valid) box_sum <= box_d;
   end

   always_ff @(posedge clk) begin
      if (valid) taps[0] <= col_new;
   end

   for (genvar i = 1; i < TAPS; i++) begin : g_tap
      always_ff @(posedge clk) begin
         if (valid) taps[i] <= taps[i-1];
      end
   end
endmodule

// File: rtl/bx_norm.sv
module bx_norm
   import bx_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int BOX_W    = 16,
   parameter int AREA     = 225,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [BOX_W-1:0] box_sum,
   output logic             out_valid,
   output logic [PIX_W-1:0] out_pix
);
   localparam longint RECIP   = recip_of(AREA);
   localparam int     RECIP_W = FRAC_BITS + 1;
   localparam int     PROD_W  = BOX_W + RECIP_W + 1;

   logic [PROD_W-1:0] prod, adj;

   always_comb prod = PROD_W'(box_sum) * PROD_W'(RECIP);

   if (ROUND_EN) begin : g_round
      always_comb adj = prod + (PROD_W'(1) << (FRAC_BITS - 1));
   end else begin : g_trunc
      always_comb adj = prod;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_pix <= PIX_W'(adj >> FRAC_BITS);
      end
   end
endmodule

// File: rtl/boxavg_stream.sv
module boxavg_stream
   import bx_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int RADIUS   = 7,
   parameter int IMG_W    = 64,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic [PIX_W-1:0] in_add,
   input  logic [PIX_W-1:0] in_sub,
   output logic             out_valid,
   output logic [PIX_W-1:0] out_pix
);
   localparam int K     = 2 * RADIUS + 1;
   localparam int COL_W = sum_width(PIX_W, K);
   localparam int BOX_W = sum_width(COL_W, K);
   localparam int CNT_W = $clog2(IMG_W);
   localparam int ROW_W = $clog2(K + 1);

   if (RADIUS < 1) begin : g_bad_radius
      $error("boxavg_stream: RADIUS must be at least 1");
   end
   if (IMG_W < K) begin : g_bad_width
      $error("boxavg_stream: IMG_W must cover the kernel width");
   end
   if (PIX_W < 1) begin : g_bad_pix
      $error("boxavg_stream: PIX_W must be positive");
   end

   logic [CNT_W-1:0] col_q, col_use;
   logic [ROW_W-1:0] row_q, row_use;
   logic             win_ok, win_q;
   logic [COL_W-1:0] col_new;
   logic [BOX_W-1:0] box_q;

   always_comb begin
      col_use = in_sof ? '0 : col_q;
      row_use = in_sof ? '0 : row_q;
      win_ok  = in_valid && (row_use >= ROW_W'(K - 1)) && (col_use >= CNT_W'(K - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
         win_q <= 1'b0;
      end else begin
         win_q <= win_ok;
         if (in_valid) begin
            if (col_use == CNT_W'(IMG_W - 1)) begin
               col_q <= '0;
               row_q <= (row_use == ROW_W'(K)) ? row_use : row_use + 1'b1;
            end else begin
               col_q <= col_use + 1'b1;
               row_q <= row_use;
            end
         end
      end
   end

   bx_colsum #(.PIX_W(PIX_W), .COL_W(COL_W), .IMG_W(IMG_W), .ADDR_W(CNT_W)) u_col (
      .clk       (clk),
      .valid     (in_valid),
      .addr      (col_use),
      .first_row (row_use == '0),
      .add_pix   (in_add),
      .sub_pix   (in_sub),
      .col_new   (col_new)
   );

   bx_rowsum #(.COL_W(COL_W), .BOX_W(BOX_W), .TAPS(K)) u_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (in_valid),
      .restart  (col_use == '0),
      .leave_en (col_use >= CNT_W'(K)),
      .col_new  (col_new),
      .box_sum  (box_q)
   );

   bx_norm #(.PIX_W(PIX_W), .BOX_W(BOX_W), .AREA(K * K), .ROUND_EN(ROUND_EN)) u_norm (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (win_q),
      .box_sum   (box_q),
      .out_valid (out_valid),
      .out_pix   (out_pix)
   );
endmodule

// File: rtl/boxavg_chk.sv
module boxavg_chk #(
   parameter int PIX_W  = 8,
   parameter int RADIUS = 7,
   parameter int COL_W  = 12,
   parameter int BOX_W  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_sof,
   input logic             out_valid,
   input logic [COL_W-1:0] col_new,
   input logic [BOX_W-1:0] box_sum
);
   localparam int     K       = 2 * RADIUS + 1;
   localparam longint PIX_MAX = (64'sd1 <<< PIX_W) - 1;
   localparam longint COL_MAX = K * PIX_MAX;
   localparam longint BOX_MAX = K * K * PIX_MAX;

   AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2)); // R2
   AST_SOF_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> ##1 !out_valid); // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##1 !out_valid); // R7
   AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (longint'(col_new) <= COL_MAX)); // R5
   AST_BOX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      longint'(box_sum) <= BOX_MAX); // R8
endmodule

bind boxavg_stream boxavg_chk #(
   .PIX_W(PIX_W), .RADIUS(RADIUS), .COL_W(COL_W), .BOX_W(BOX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sof    (in_sof),
   .out_valid (out_valid),
   .col_new   (col_new),
   .box_sum   (box_q)
);

// File: tb/sim_boxavg_stream.sv
module sim_boxavg_stream;
   localparam int W   = 18;
   localparam int H   = 17;
   localparam int RAD = 7;
   localparam int K   = 2 * RAD + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_sof = 1'b0;
   logic [7:0] in_add = '0;
   logic [7:0] in_sub = '0;
   logic       out_valid;
   logic [7:0] out_pix;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string tag = "R3";
   int    exp_q[$];
   int    img [H][W];

   always #10 clk = ~clk;

   boxavg_stream #(.PIX_W(8), .RADIUS(RAD), .IMG_W(W), .ROUND_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_add(in_add), .in_sub(in_sub), .out_valid(out_valid), .out_pix(out_pix)
   );

   task automatic chk(input bit ok, input string t, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R4 unexpected result", out_pix, -1);
         else begin
            int e;
            e = exp_q.pop_front();
            chk(out_pix == e, tag, out_pix, e);
         end
      end
   end

   task automatic beat(input bit v, input bit s, input int a, input int b);
      in_valid = v; in_sof = s; in_add = 8'(a); in_sub = 8'(b);
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) beat(1'b0, 1'b1, 8'hA5 + i, 8'h3C);
      in_sof = 1'b0;
   endtask

   function automatic int window_avg(input int r, input int c);
      int s = 0;
      for (int y = r - K + 1; y <= r; y++)
         for (int x = c - K + 1; x <= c; x++) s += img[y][x];
      return (s + 112) / 225;
   endfunction

   task automatic fill(input int kind);
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++)
            case (kind)
               0: img[r][c] = 255;
               1: img[r][c] = (r * 13 + c * 7) & 255;
               2: img[r][c] = (r * 37 + c * 91 + 11) & 255;
               3: img[r][c] = (r == 14 && c == 14) ? 112 : ((r == 16 && c == 17) ? 1 : 0);
               default: img[r][c] = (r * c * 5 + 3) & 255;
            endcase
   endtask

   task automatic drive(input int npix, input int gap_every);
      int n = 0;
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++) begin
            if (n < npix) begin
               if (gap_every > 0 && (n % gap_every) == gap_every - 1) idle(2);
               if (r >= K - 1 && c >= K - 1) exp_q.push_back(window_avg(r, c));
               beat(1'b1, n == 0, img[r][c], (r >= K) ? img[r - K][c] : 0);
               n++;
            end
         end
      in_valid = 1'b0; in_sof = 1'b0;
   endtask

   task automatic settle(input string t);
      idle(4);
      chk(exp_q.size() == 0, t, exp_q.size(), 0);
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      #1;
      chk(out_valid == 1'b0, "R1 during reset", out_valid, 0);
      rst_n = 1'b1;
      idle(3);
      chk(out_valid == 1'b0, "R1 after reset", out_valid, 0);
   endtask

   task automatic t_const();
      tag = "R8 all-max window";
      fill(0); drive(H * W, 0); settle("R4 count const");
   endtask

   task automatic t_ramp();
      tag = "R3 ramp window";
      fill(1); drive(H * W, 0); settle("R4 count ramp");
      tag = "R5 column sums across frames";
      fill(2); drive(H * W, 0); settle("R4 count second frame");
   endtask

   task automatic t_gaps();
      tag = "R7 gapped stream";
      fill(4); drive(H * W, 5); settle("R7 count with gaps");
   endtask

   task automatic t_restart();
      tag = "R6 aborted frame";
      fill(2); drive(K * W + 16, 0);
      tag = "R6 restarted frame";
      fill(1); drive(H * W, 0); settle("R6 count after restart");
   endtask

   task automatic t_round();
      tag = "R9 rounding";
      fill(3); drive(H * W, 0); settle("R9 count");
   endtask

   task automatic t_latency();
      tag = "R2 latency value";
      fill(4);
      drive(H * W - 1, 0);
      idle(3);
      exp_q.push_back(window_avg(H - 1, W - 1));
      beat(1'b1, 1'b0, img[H-1][W-1], img[H-1-K][W-1]);
      in_valid = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 one edge after", out_valid, 0);
      @(posedge clk); @(negedge clk);
      chk(out_valid == 1'b1, "R2 two edges after", out_valid, 1);
      settle("R2 drained");
   endtask

   initial begin
      t_reset();
      t_const();
      t_ramp();
      t_gaps();
      t_restart();
      t_round();
      t_latency();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule